// File: doc/BRIEF.md
# Status Register and Block Write Protection Controller

This block sits beside the command decoder and write engine of a serial nonvolatile memory. It holds the device status fields: a protect-lock enable bit, a two-bit protection level, the write enable latch and the busy flag. From those fields, the write protect pin and the engine status, it decides for every candidate write whether the write may proceed. The candidate is either a data-array address or the status register itself. It also assembles the byte that a status-read command shifts out.

The command decoder passes single-cycle events to the block: set latch, clear latch, and "status data byte received". It also passes the chip-select level and the address being tested. A status update is staged when its data byte arrives. It is committed on the cycle in which chip select is seen deasserted, unless the hardware lock becomes active first. The write engine reports its internal cycle on `cyc_busy`. The end of any internal cycle clears the write enable latch. The nonvolatile fields are modelled as registers that reset to zero.

The controller has three named states. ST_IDLE waits for commands. ST_STAGED holds a status update until chip select rises. ST_CYCLE waits for the write engine to finish. The transitions are:
- ST_IDLE to ST_STAGED on a permitted data byte.
- ST_STAGED to ST_IDLE on commit (chip select high) or on cancel (hardware lock active).
- Any state to ST_CYCLE while `cyc_busy` is high.
- ST_CYCLE to ST_IDLE when `cyc_busy` drops.

Top module: `wp_status_ctl`

## Requirements
- R1: After reset, `status_byte` is 8'h00, both permits are 0 and `sr_commit` is 0 while `cyc_busy` is low.
- R2: Outside an internal cycle, `op_wren` sets the write enable latch and `op_wrdi` clears it, whatever the level of `wp_n`. `op_wrdi` wins when both are pulsed. The latch is seen in `status_byte` bit 1 in the cycle after the event.
- R3: `arr_wr_ok` is 1 only when the latch is set, `cyc_busy` is low and `addr` lies outside the protected range. The range is selected by the level in `status_byte[3:2]`: 00 protects nothing, 01 protects addresses with both top address bits at 1, 10 protects addresses with the top address bit at 1, and 11 protects every address.
- R4: `sr_wr_ok` is 1 only when the latch is set, `cyc_busy` is low and the hardware lock is off. The lock is on when `wp_n` is 0 and the lock-enable bit (`status_byte[7]`) is 1.
- R5: A `sr_load` pulse while `sr_wr_ok` is 1 stages bits 7, 3 and 2 of `sr_data`. In a later cycle with `sel_n` high and the lock off, `sr_commit` is 1 and the staged bits appear in `status_byte` from the next cycle. A `sr_load` while `sr_wr_ok` is 0 is ignored.
- R6: If the hardware lock turns on while an update is staged, the update is dropped. No commit follows and the stored fields are left unchanged.
- R7: While `cyc_busy` is 1, `status_byte` reads 8'hFF, both permits are 0, and `op_wren`, `op_wrdi` and `sr_load` have no effect. A staged update is dropped when `cyc_busy` rises.
- R8: The cycle after `cyc_busy` falls, the write enable latch reads 0.
- R9: While `cyc_busy` is 0, `status_byte[6:4]` and `status_byte[0]` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sel_n | input | 1 | Chip select level, low while a command frame is open |
| wp_n | input | 1 | Write protect pin, low requests hardware lock |
| op_wren | input | 1 | One-cycle event: set write enable latch |
| op_wrdi | input | 1 | One-cycle event: clear write enable latch |
| sr_load | input | 1 | One-cycle event: status data byte received |
| sr_data | input | 8 | Received status data byte |
| addr | input | ADDR_W | Array address under test |
| cyc_busy | input | 1 | Write engine internal cycle in progress |
| arr_wr_ok | output | 1 | Array write to `addr` permitted |
| sr_wr_ok | output | 1 | Status register write permitted |
| sr_commit | output | 1 | Staged status update is committed this cycle |
| status_byte | output | 8 | Byte returned by a status read |

## Verification
The permits, `sr_commit` and `status_byte` are combinational functions of the stored state and the present inputs. They are due in the same cycle as the stimulus. The stored fields (latch, level, lock-enable and staged update) change at the next rising edge. The bench drives every input just after a falling edge and compares all outputs 1 ns later against a model built from the requirements. It then advances that model at the rising edge, using the same inputs. As a result, a register effect is first compared one cycle after its cause, and a combinational effect is compared in the cycle of its cause.

// File: rtl/wpsr_pkg.sv
package wpsr_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_STAGED = 2'd1,
        ST_CYCLE  = 2'd2
    } sr_state_t;

    typedef struct packed {
        logic       lock_en;
        logic [1:0] level;
    } prot_cfg_t;

    localparam int SB_LOCK   = 7;
    localparam int SB_LVL_HI = 3;
    localparam int SB_LVL_LO = 2;
    localparam int SB_WEL    = 1;
    localparam int SB_BUSY   = 0;

    localparam logic [1:0] LVL_NONE    = 2'b00;
    localparam logic [1:0] LVL_QUARTER = 2'b01;
    localparam logic [1:0] LVL_HALF    = 2'b10;
    localparam logic [1:0] LVL_ALL     = 2'b11;

endpackage

// File: rtl/wp_region_decode.sv
module wp_region_decode #(
    parameter int ADDR_W = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        level,
    output logic              in_prot
);
    import wpsr_pkg::*;

    localparam int TOP = ADDR_W - 1;
    localparam int NXT = ADDR_W - 2;

    always_comb begin
        unique case (level)
            LVL_NONE:    in_prot = 1'b0;
            LVL_QUARTER: in_prot = addr[TOP] & addr[NXT];
            LVL_HALF:    in_prot = addr[TOP];
            LVL_ALL:     in_prot = 1'b1;
            default:     in_prot = 1'b1;
        endcase
    end
endmodule

// File: rtl/wp_status_fmt.sv
module wp_status_fmt (
    input  wpsr_pkg::prot_cfg_t cfg,
    input  logic                wel,
    input  logic                busy,
    output logic [7:0]          sbyte
);
    import wpsr_pkg::*;

    always_comb begin
        sbyte = 8'h00;
        if (busy) begin
            sbyte = 8'hFF;
        end else begin
            sbyte[SB_LOCK]             = cfg.lock_en;
            sbyte[SB_LVL_HI:SB_LVL_LO] = cfg.level;
            sbyte[SB_WEL]              = wel;
            sbyte[SB_BUSY]             = 1'b0;
        end
    end
endmodule

// File: rtl/wp_status_ctl.sv
module wp_status_ctl #(
    parameter int ADDR_W = 13
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              wp_n,
    input  logic              op_wren,
    input  logic              op_wrdi,
    input  logic              sr_load,
    input  logic [7:0]        sr_data,
    input  logic [ADDR_W-1:0] addr,
    input  logic              cyc_busy,
    output logic              arr_wr_ok,
    output logic              sr_wr_ok,
    output logic              sr_commit,
    output logic [7:0]        status_byte
);
    import wpsr_pkg::*;

    sr_state_t state, state_nx;
    prot_cfg_t cfg_q, stage_q;
    logic      wel_q;
    logic      in_prot;
    logic      hw_lock;
    logic      cmd_open;
    logic      take_load;
    logic      cycle_end;

    wp_region_decode #(.ADDR_W(ADDR_W)) u_region (
        .addr    (addr),
        .level   (cfg_q.level),
        .in_prot (in_prot)
    );

    wp_status_fmt u_fmt (
        .cfg   (cfg_q),
        .wel   (wel_q),
        .busy  (cyc_busy),
        .sbyte (status_byte)
    );

    // Output process: permits, commit strobe, command acceptance.
    always_comb begin
        hw_lock   = ~wp_n & cfg_q.lock_en;
        cmd_open  = ~cyc_busy & (state != ST_CYCLE);
        sr_wr_ok  = ~cyc_busy & wel_q & ~hw_lock;
        arr_wr_ok = ~cyc_busy & wel_q & ~in_prot;
        take_load = cmd_open & sr_load & sr_wr_ok;
        sr_commit = (state == ST_STAGED) & ~cyc_busy & ~hw_lock & sel_n;
        cycle_end = (state == ST_CYCLE) & ~cyc_busy;
    end

    // Next-state logic.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (cyc_busy)       state_nx = ST_CYCLE;
                else if (take_load) state_nx = ST_STAGED;
            end
            ST_STAGED: begin
                if (cyc_busy)     state_nx = ST_CYCLE;
                else if (hw_lock) state_nx = ST_IDLE;
                else if (sel_n)   state_nx = ST_IDLE;
            end
            ST_CYCLE: begin
                if (!cyc_busy)    state_nx = ST_IDLE;
            end
            default:              state_nx = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Field registers.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wel_q   <= 1'b0;
            cfg_q   <= '0;
            stage_q <= '0;
        end else begin
            if (cycle_end)                wel_q <= 1'b0;
            else if (cmd_open && op_wrdi) wel_q <= 1'b0;
            else if (cmd_open && op_wren) wel_q <= 1'b1;

            if (take_load) begin
                stage_q.lock_en <= sr_data[SB_LOCK];
                stage_q.level   <= sr_data[SB_LVL_HI:SB_LVL_LO];
            end

            if (sr_commit) cfg_q <= stage_q;
        end
    end
endmodule

// File: rtl/wp_status_chk.sv
module wp_status_chk #(
    parameter int ADDR_W = 13
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wp_n,
    input logic              op_wren,
    input logic              op_wrdi,
    input logic              cyc_busy,
    input logic              arr_wr_ok,
    input logic              sr_wr_ok,
    input logic              sr_commit,
    input logic [7:0]        status_byte
);
    a_r7_busy_reads_ff: assert property (@(posedge clk) disable iff (!rst_n)
        cyc_busy |-> (status_byte == 8'hFF && !arr_wr_ok && !sr_wr_ok));

    a_r3_full_level_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!cyc_busy && status_byte[3:2] == 2'b11) |-> !arr_wr_ok);

    a_r4_hw_lock_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!wp_n && !cyc_busy && status_byte[7]) |-> !sr_wr_ok);

    a_r2_wren_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wren && !op_wrdi && !cyc_busy && !$fell(cyc_busy)) |=> status_byte[1]);

    a_r8_cycle_end_clears: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cyc_busy) |=> (cyc_busy || !status_byte[1]));

    a_r6_no_commit_locked: assert property (@(posedge clk) disable iff (!rst_n)
        sr_commit |-> !(!wp_n && status_byte[7]));

    a_r9_idle_bits_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_busy |-> (status_byte[6:4] == 3'b000 && !status_byte[0]));
endmodule

bind wp_status_ctl wp_status_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wp_n        (wp_n),
    .op_wren     (op_wren),
    .op_wrdi     (op_wrdi),
    .cyc_busy    (cyc_busy),
    .arr_wr_ok   (arr_wr_ok),
    .sr_wr_ok    (sr_wr_ok),
    .sr_commit   (sr_commit),
    .status_byte (status_byte)
);

// File: tb/tb_wp_status_ctl.sv
module tb_wp_status_ctl;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          sel_n = 1'b1;
    logic          wp_n = 1'b1;
    logic          op_wren = 1'b0;
    logic          op_wrdi = 1'b0;
    logic          sr_load = 1'b0;
    logic [7:0]    sr_data = 8'h00;
    logic [AW-1:0] addr = '0;
    logic          cyc_busy = 1'b0;
    logic          arr_wr_ok, sr_wr_ok, sr_commit;
    logic [7:0]    status_byte;

    int n_chk = 0;
    int n_err = 0;

    // reference model state
    logic       m_wel, m_lock, m_stg, m_stg_lock, m_cyc;
    logic [1:0] m_lvl, m_stg_lvl;

    always #4 clk = ~clk;

    wp_status_ctl #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .wp_n(wp_n),
        .op_wren(op_wren), .op_wrdi(op_wrdi), .sr_load(sr_load),
        .sr_data(sr_data), .addr(addr), .cyc_busy(cyc_busy),
        .arr_wr_ok(arr_wr_ok), .sr_wr_ok(sr_wr_ok),
        .sr_commit(sr_commit), .status_byte(status_byte)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
        end
    endtask

    function automatic logic f_prot(input logic [AW-1:0] a, input logic [1:0] lvl);
        int unsigned v = a;
        case (lvl)
            2'b00:   return 1'b0;
            2'b01:   return v >= 3 * (1 << (AW - 2));
            2'b10:   return v >= (1 << (AW - 1));
            default: return 1'b1;
        endcase
    endfunction

    function automatic logic f_lock();
        return !wp_n && m_lock;
    endfunction

    function automatic logic [7:0] f_status();
        if (cyc_busy) return 8'hFF;
        return {m_lock, 3'b000, m_lvl, m_wel, 1'b0};
    endfunction

    task automatic model_reset();
        m_wel = 0; m_lock = 0; m_lvl = 0; m_stg = 0;
        m_stg_lock = 0; m_stg_lvl = 0; m_cyc = 0;
    endtask

    task automatic compare_all();
        logic sr_ok;
        sr_ok = !cyc_busy && m_wel && !f_lock();
        chk(cyc_busy ? "R7 status" : "R9 status", status_byte, f_status());
        chk("R3 arr_wr_ok", {7'd0, arr_wr_ok},
            {7'd0, !cyc_busy && m_wel && !f_prot(addr, m_lvl)});
        chk("R4 sr_wr_ok", {7'd0, sr_wr_ok}, {7'd0, sr_ok});
        chk("R5 sr_commit", {7'd0, sr_commit},
            {7'd0, m_stg && !cyc_busy && !f_lock() && sel_n});
    endtask

    task automatic model_step();
        logic sr_ok;
        sr_ok = !cyc_busy && m_wel && !f_lock();
        if (cyc_busy) begin
            m_cyc = 1; m_stg = 0;
        end else if (m_cyc) begin
            m_cyc = 0; m_wel = 0;
        end else begin
            if (m_stg) begin
                if (f_lock()) m_stg = 0;
                else if (sel_n) begin
                    m_lock = m_stg_lock; m_lvl = m_stg_lvl; m_stg = 0;
                end
            end
            if (sr_load && sr_ok) begin
                m_stg = 1; m_stg_lock = sr_data[7]; m_stg_lvl = sr_data[3:2];
            end
            if (op_wrdi) m_wel = 0;
            else if (op_wren) m_wel = 1;
        end
    endtask

    // inputs already set just after a falling edge
    task automatic tick();
        #1;
        compare_all();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle_inputs();
        op_wren = 0; op_wrdi = 0; sr_load = 0;
    endtask

    task automatic wrsr(input logic [7:0] d);
        sel_n = 0; op_wren = 1; tick(); idle_inputs();
        sr_load = 1; sr_data = d; tick(); idle_inputs();
        sel_n = 1; tick(); sel_n = 0;
    endtask

    initial begin
        #(8 * 200000);
        n_err++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        int unsigned r;
        r = $urandom(32'd9157);
        model_reset();
        repeat (3) @(negedge clk);
        #1;
        chk("R1 reset status", status_byte, 8'h00);
        chk("R1 reset permits", {6'd0, arr_wr_ok, sr_wr_ok}, 8'h00);
        chk("R1 reset commit", {7'd0, sr_commit}, 8'h00);
        @(negedge clk);
        rst_n = 1;
        sel_n = 0;
        tick();

        // R2: latch set and cleared with wp_n low
        wp_n = 0; op_wren = 1; tick(); idle_inputs();
        #1; chk("R2 wren with wp low", {7'd0, status_byte[1]}, 8'h01);
        @(negedge clk);
        op_wrdi = 1; op_wren = 1; tick(); idle_inputs();
        #1; chk("R2 wrdi wins", {7'd0, status_byte[1]}, 8'h00);
        @(negedge clk);
        wp_n = 1;

        // R3 boundaries at quarter level
        wrsr(8'h04);
        op_wren = 1; tick(); idle_inputs();
        addr = 13'h17FF; tick();
        #1; chk("R3 quarter below", {7'd0, arr_wr_ok}, 8'h01); @(negedge clk);
        addr = 13'h1800; tick();
        #1; chk("R3 quarter edge", {7'd0, arr_wr_ok}, 8'h00); @(negedge clk);
        wrsr(8'h08);
        op_wren = 1; tick(); idle_inputs();
        addr = 13'h0FFF; tick();
        addr = 13'h1000; tick();
        #1; chk("R3 half edge", {7'd0, arr_wr_ok}, 8'h00); @(negedge clk);

        // R5 set lock enable, then R4 lock and R6 cancel
        wrsr(8'h80);
        #1; chk("R5 lock bit stored", status_byte & 8'h8C, 8'h80); @(negedge clk);
        op_wren = 1; tick(); idle_inputs();
        sr_load = 1; sr_data = 8'h0C; tick(); idle_inputs();
        wp_n = 0; tick();
        #1; chk("R4 locked permit", {7'd0, sr_wr_ok}, 8'h00); @(negedge clk);
        wp_n = 1; sel_n = 1; tick(); sel_n = 0; tick();
        #1; chk("R6 cancel kept fields", status_byte & 8'h8C, 8'h80); @(negedge clk);

        // R7 and R8: busy window, then latch cleared
        op_wren = 1; tick(); idle_inputs();
        cyc_busy = 1; op_wrdi = 1; tick(); idle_inputs();
        #1; chk("R7 busy byte", status_byte, 8'hFF); @(negedge clk);
        cyc_busy = 0; tick();
        tick();
        #1; chk("R8 latch cleared", {7'd0, status_byte[1]}, 8'h00); @(negedge clk);

        // constrained random
        for (int i = 0; i < 4000; i++) begin
            if (cyc_busy) cyc_busy = ($urandom % 6) != 0;
            else          cyc_busy = ($urandom % 20) == 0;
            sel_n   = ($urandom % 10) == 0;
            if (($urandom % 8) == 0) wp_n = ~wp_n;
            op_wren = ($urandom % 5) == 0;
            op_wrdi = ($urandom % 12) == 0;
            sr_load = !sel_n && (($urandom % 6) == 0);
            sr_data = 8'($urandom);
            case ($urandom % 4)
                0:       addr = 13'h17FF + 13'($urandom % 2);
                1:       addr = 13'h0FFF + 13'($urandom % 2);
                default: addr = AW'($urandom);
            endcase
            tick();
        end

        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule